// File: doc/BRIEF.md
# Precision Time Counter with Event Capture

This block keeps a free-running 64-bit time value for an Ethernet controller that timestamps precision-time-protocol frames. Software programs it over a simple register port. One register sets how fast the time advances. Two registers load or read the low and high halves of the time. A control register halts the counter and selects between two formats. In raw binary format the two halves form one 64-bit count. In split format the low half counts nanoseconds and the high half counts seconds.

Two capture channels, one for received event frames and one for transmitted event frames, each take a copy of the time when a one-cycle pulse arrives. Each channel raises a flag at that point. Software polls the flag, reads the low word, and then reads the high word, which frees the channel for the next event. Frame parsing, rate servoing and conversion of raw counts to nanoseconds happen elsewhere.

Top module: `ptp_clock_core`

## Requirements
- R1: After reset the rate register reads 0, the control register reads 1 (halted, binary format), both time halves read 0 and both capture status registers read 0.
- R2: The time does not change while control bit 0 (halt) is 1, or while the rate register is zero.
- R3: In binary format (control bit 1 = 0), rate bits 31:24 give a period P in clock cycles and bits 23:0 give an amount V. V is added, with carry, to the 64-bit value {high, low} once every P running cycles. P = 0 stops the count, and a write to the rate register restarts the period count.
- R4: In split format (control bit 1 = 1), the full 32-bit rate is added to the low half every running cycle. When the result reaches 1,000,000,000, the low half takes the result minus 1,000,000,000 and the high half increases by one.
- R5: A write to address 1 loads the low half and a write to address 2 loads the high half. In the cycle of a time write the counter does not advance, so writing zero to both halves leaves the time at zero.
- R6: A read of the low half (address 1) copies the high half at that moment. A later read of the high half (address 2) returns that copy, not the live value.
- R7: The receive channel (status 4, low 5, high 6) and the transmit channel (status 7, low 8, high 9) each latch the current time on a pulse of rx_evt or tx_evt while their flag is clear, and then set the flag, which reads as bit 0 of the status register.
- R8: While a channel's flag is set, further event pulses on that channel leave its latched value unchanged.
- R9: Reading a channel's high word clears its flag. While a flag is clear, that channel's low and high words read as zero.
- R10: Read data appears on rdata in the cycle after rd_en and is zero in any cycle that follows a cycle without rd_en. The rate register is at address 0 and the control register at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rx_evt | input | 1 | Receive event pulse |
| tx_evt | input | 1 | Transmit event pulse |

## Verification
The nanosecond-range assertions assume two things in split format: the low half never holds a value of one billion or more, and the rate is below one billion. For that reason they only apply when both conditions hold. The stimulus loads only valid nanosecond values and rates in split format. Event pulses are single-cycle, and time writes are made with the counter halted, except where a write during counting is itself the subject of the check.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;
  localparam int unsigned A_STEP     = 0;
  localparam int unsigned A_TLO      = 1;
  localparam int unsigned A_THI      = 2;
  localparam int unsigned A_CTRL     = 3;
  localparam int unsigned CAP_BASE   = 4;
  localparam int unsigned CAP_STRIDE = 3;
  localparam int unsigned CAP_STAT   = 0;
  localparam int unsigned CAP_LO     = 1;
  localparam int unsigned CAP_HI     = 2;
  localparam int unsigned CTRL_HALT  = 0;
  localparam int unsigned CTRL_SPLIT = 1;
endpackage

// File: rtl/ptp_rate_gen.sv
module ptp_rate_gen #(
  parameter int unsigned DW    = 32,
  parameter int unsigned PER_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] step,
  input  logic          step_wr,
  input  logic          halt,
  input  logic          split,
  output logic          adv,
  output logic [DW-1:0] inc
);
  localparam int unsigned VAL_W = DW - PER_W;

  logic [PER_W-1:0] per;
  logic [VAL_W-1:0] val;
  logic [PER_W-1:0] ph_q;
  logic             run;
  logic             ph_end;

  assign per    = step[DW-1 -: PER_W];
  assign val    = step[VAL_W-1:0];
  assign run    = !halt && (step != '0) && (split || per != '0);
  assign ph_end = (ph_q == PER_W'(per - 1'b1));

  always_ff @(posedge clk) begin
    if (rst || step_wr) begin
      ph_q <= '0;
    end else if (run && !split) begin
      if (ph_end) ph_q <= '0;
      else        ph_q <= ph_q + 1'b1;
    end
  end

  assign adv = run && (split || ph_end);
  assign inc = split ? step : {{PER_W{1'b0}}, val};

  // R3: phase counter stays inside the programmed period
  a_r3_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    (ph_q < per && !step_wr) |=> (ph_q < per));

  // R2: a halted counter never produces an advance
  a_r2_halt_no_adv: assert property (@(posedge clk) disable iff (rst)
    halt |-> !adv);
endmodule

// File: rtl/ptp_time_acc.sv
module ptp_time_acc #(
  parameter int unsigned   DW      = 32,
  parameter logic [DW-1:0] NS_WRAP = DW'(1_000_000_000)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [DW-1:0] inc,
  input  logic          split,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] lo_q,
  output logic [DW-1:0] hi_q
);
  logic [2*DW-1:0] bin_nx;
  logic [DW:0]     ns_sum;
  logic            wrap;
  logic [DW-1:0]   ns_lo_nx;

  assign bin_nx   = {hi_q, lo_q} + {{DW{1'b0}}, inc};
  assign ns_sum   = {1'b0, lo_q} + {1'b0, inc};
  assign wrap     = (ns_sum >= {1'b0, NS_WRAP});
  assign ns_lo_nx = wrap ? DW'(ns_sum - {1'b0, NS_WRAP}) : ns_sum[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (ld_lo || ld_hi) begin
      if (ld_lo) lo_q <= ld_val;
      if (ld_hi) hi_q <= ld_val;
    end else if (adv) begin
      if (split) begin
        lo_q <= ns_lo_nx;
        hi_q <= hi_q + DW'(wrap);
      end else begin
        {hi_q, lo_q} <= bin_nx;
      end
    end
  end

  // R3: binary advance adds exactly the amount with carry into the high half
  a_r3_bin_sum: assert property (@(posedge clk) disable iff (rst)
    (!split && adv && !ld_lo && !ld_hi) |=>
    (({hi_q, lo_q} - $past({hi_q, lo_q})) == {{DW{1'b0}}, $past(inc)}));

  // R4: nanoseconds stay below one billion
  a_r4_ns_below_wrap: assert property (@(posedge clk) disable iff (rst)
    (split && adv && !ld_lo && !ld_hi && lo_q < NS_WRAP && inc < NS_WRAP) |=>
    (lo_q < NS_WRAP));

  // R4: seconds move by at most one per advance
  a_r4_sec_step: assert property (@(posedge clk) disable iff (rst)
    (split && adv && !ld_lo && !ld_hi && lo_q < NS_WRAP && inc < NS_WRAP) |=>
    (hi_q == $past(hi_q) || hi_q == $past(hi_q) + 1'b1));

  // R5: a low-half write lands unchanged
  a_r5_load_lo: assert property (@(posedge clk) disable iff (rst)
    ld_lo |=> (lo_q == $past(ld_val)));
endmodule

// File: rtl/ptp_capture.sv
module ptp_capture #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt,
  input  logic          clr,
  input  logic [DW-1:0] now_lo,
  input  logic [DW-1:0] now_hi,
  output logic          valid_q,
  output logic [DW-1:0] lo_q,
  output logic [DW-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (clr) begin
      valid_q <= 1'b0;
    end else if (evt && !valid_q) begin
      valid_q <= 1'b1;
      lo_q    <= now_lo;
      hi_q    <= now_hi;
    end
  end

  // R7: a pulse on a free channel takes the current time
  a_r7_take: assert property (@(posedge clk) disable iff (rst)
    (evt && !valid_q && !clr) |=>
    (valid_q && lo_q == $past(now_lo) && hi_q == $past(now_hi)));

  // R8: a full channel keeps its value
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !clr) |=> ($stable(lo_q) && $stable(hi_q) && valid_q));

  // R9: a high-word read frees the channel
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !valid_q);
endmodule

// File: rtl/ptp_clock_core.sv
module ptp_clock_core #(
  parameter int unsigned   DW      = 32,
  parameter int unsigned   ADDR_W  = 4,
  parameter int unsigned   PER_W   = 8,
  parameter int unsigned   N_CAP   = 2,
  parameter logic [DW-1:0] NS_WRAP = DW'(1_000_000_000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              rx_evt,
  input  logic              tx_evt
);
  import ptp_clk_pkg::*;

  logic [DW-1:0] step_q;
  logic          halt_q;
  logic          split_q;
  logic [DW-1:0] snap_hi_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rd_mux;

  logic          step_wr, ld_lo, ld_hi, ctrl_wr, rd_lo;
  logic          adv;
  logic [DW-1:0] inc;
  logic [DW-1:0] time_lo, time_hi;

  logic [N_CAP-1:0] cap_evt;
  logic [N_CAP-1:0] cap_clr;
  logic [N_CAP-1:0] cap_valid;
  logic [DW-1:0]    cap_lo [N_CAP];
  logic [DW-1:0]    cap_hi [N_CAP];

  assign step_wr = wr_en && (addr == ADDR_W'(A_STEP));
  assign ld_lo   = wr_en && (addr == ADDR_W'(A_TLO));
  assign ld_hi   = wr_en && (addr == ADDR_W'(A_THI));
  assign ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));
  assign rd_lo   = rd_en && (addr == ADDR_W'(A_TLO));

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= '0;
      halt_q    <= 1'b1;
      split_q   <= 1'b0;
      snap_hi_q <= '0;
    end else begin
      if (step_wr) step_q <= wdata;
      if (ctrl_wr) begin
        halt_q  <= wdata[CTRL_HALT];
        split_q <= wdata[CTRL_SPLIT];
      end
      if (rd_lo) snap_hi_q <= time_hi;
    end
  end

  ptp_rate_gen #(.DW(DW), .PER_W(PER_W)) u_rate (
    .clk(clk), .rst(rst), .step(step_q), .step_wr(step_wr),
    .halt(halt_q), .split(split_q), .adv(adv), .inc(inc)
  );

  ptp_time_acc #(.DW(DW), .NS_WRAP(NS_WRAP)) u_acc (
    .clk(clk), .rst(rst), .adv(adv), .inc(inc), .split(split_q),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_val(wdata),
    .lo_q(time_lo), .hi_q(time_hi)
  );

  assign cap_evt[0] = rx_evt;
  generate
    if (N_CAP > 1) begin : g_tx_evt
      assign cap_evt[1] = tx_evt;
    end
    if (N_CAP > 2) begin : g_spare_evt
      assign cap_evt[N_CAP-1:2] = '0;
    end
  endgenerate

  genvar g;
  generate
    for (g = 0; g < N_CAP; g++) begin : g_cap
      assign cap_clr[g] = rd_en &&
        (addr == ADDR_W'(CAP_BASE + CAP_STRIDE * g + CAP_HI));
      ptp_capture #(.DW(DW)) u_cap (
        .clk(clk), .rst(rst), .evt(cap_evt[g]), .clr(cap_clr[g]),
        .now_lo(time_lo), .now_hi(time_hi),
        .valid_q(cap_valid[g]), .lo_q(cap_lo[g]), .hi_q(cap_hi[g])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(A_STEP)) rd_mux = step_q;
    if (addr == ADDR_W'(A_TLO))  rd_mux = time_lo;
    if (addr == ADDR_W'(A_THI))  rd_mux = snap_hi_q;
    if (addr == ADDR_W'(A_CTRL)) rd_mux = {{(DW-2){1'b0}}, split_q, halt_q};
    for (int c = 0; c < N_CAP; c++) begin
      if (addr == ADDR_W'(CAP_BASE + CAP_STRIDE * c + CAP_STAT))
        rd_mux = {{(DW-1){1'b0}}, cap_valid[c]};
      if (addr == ADDR_W'(CAP_BASE + CAP_STRIDE * c + CAP_LO))
        rd_mux = cap_valid[c] ? cap_lo[c] : '0;
      if (addr == ADDR_W'(CAP_BASE + CAP_STRIDE * c + CAP_HI))
        rd_mux = cap_valid[c] ? cap_hi[c] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_en ? rd_mux : '0;
  end

  assign rdata = rdata_q;

  // R2: halted or zero-rate counter keeps its time unless software writes it
  a_r2_stopped: assert property (@(posedge clk) disable iff (rst)
    ((halt_q || step_q == '0) && !ld_lo && !ld_hi) |=>
    ($stable(time_lo) && $stable(time_hi)));

  // R6: the low read keeps the high half it saw
  a_r6_snapshot: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> (snap_hi_q == $past(time_hi)));

  // R10: no read strobe, no read data
  a_r10_rd_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
endmodule

// File: tb/sim_ptp_clock_core.sv
module sim_ptp_clock_core;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        split;
    logic [31:0] step;
    logic [31:0] lo0;
    logic [31:0] hi0;
    logic [7:0]  n;
    logic [31:0] elo;
    logic [31:0] ehi;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h01CCCCCC, 32'h0,        32'h0,        8'd4, 32'h03333330, 32'h0,        4'd3},
    '{1'b0, 32'h01800000, 32'hFF000000, 32'h5,        8'd3, 32'h00800000, 32'h6,        4'd3},
    '{1'b0, 32'h04000010, 32'h0,        32'h0,        8'd8, 32'h00000020, 32'h0,        4'd3},
    '{1'b1, 32'h00000001, 32'h3B9AC9FE, 32'h7,        8'd3, 32'h00000001, 32'h8,        4'd4},
    '{1'b1, 32'h00000008, 32'h3B9AC9F6, 32'hFFFFFFFF, 8'd2, 32'h00000006, 32'h0,        4'd4},
    '{1'b0, 32'h00000000, 32'h00001234, 32'h55,       8'd5, 32'h00001234, 32'h55,       4'd2},
    '{1'b0, 32'h00000010, 32'h00000010, 32'h0,        8'd4, 32'h00000010, 32'h0,        4'd3},
    '{1'b1, 32'h1DCD6500, 32'h0,        32'h0,        8'd5, 32'h1DCD6500, 32'h2,        4'd4}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_evt = 1'b0;
  logic        tx_evt = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_clock_core u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_evt(rx_evt), .tx_evt(tx_evt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic run_for(input logic split, input int n);
    wr(4'd3, {30'd0, split, 1'b0});
    repeat (n - 1) @(negedge clk);
    wr(4'd3, {30'd0, split, 1'b1});
  endtask

  task automatic pulse(input int ch);
    if (ch == 0) rx_evt = 1'b1; else tx_evt = 1'b1;
    @(negedge clk);
    rx_evt = 1'b0; tx_evt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); check("R1 rate", v, 32'h0);
    rd(4'd3, v); check("R1 ctrl", v, 32'h1);
    rd(4'd1, v); check("R1 time lo", v, 32'h0);
    rd(4'd2, v); check("R1 time hi", v, 32'h0);
    rd(4'd4, v); check("R1 rx status", v, 32'h0);
    rd(4'd7, v); check("R1 tx status", v, 32'h0);
    // R10 idle read data
    @(negedge clk);
    check("R10 idle rdata", rdata, 32'h0);

    // table walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      wr(4'd3, {30'd0, VECS[i].split, 1'b1});
      wr(4'd0, VECS[i].step);
      wr(4'd1, VECS[i].lo0);
      wr(4'd2, VECS[i].hi0);
      run_for(VECS[i].split, int'(VECS[i].n));
      rd(4'd1, v);
      check($sformatf("R%0d vec%0d lo", VECS[i].req, i), v, VECS[i].elo);
      rd(4'd2, v);
      check($sformatf("R%0d vec%0d hi", VECS[i].req, i), v, VECS[i].ehi);
    end

    // R2 halt bit with a nonzero rate
    wr(4'd3, 32'h1);
    wr(4'd0, 32'h01000001);
    wr(4'd1, 32'h5);
    repeat (10) @(negedge clk);
    rd(4'd1, v); check("R2 halted lo", v, 32'h5);

    // R5 zero load clears
    wr(4'd1, 32'h0);
    wr(4'd2, 32'h0);
    rd(4'd1, v); check("R5 cleared lo", v, 32'h0);
    rd(4'd2, v); check("R5 cleared hi", v, 32'h0);

    // R6 high snapshot
    wr(4'd1, 32'hA0);
    wr(4'd2, 32'h11);
    rd(4'd1, v);
    wr(4'd2, 32'h22);
    rd(4'd2, v); check("R6 snapshot hi", v, 32'h11);
    rd(4'd1, v);
    rd(4'd2, v); check("R6 fresh hi", v, 32'h22);

    // R7 R8 R9 receive capture
    wr(4'd1, 32'h11111111);
    wr(4'd2, 32'h22222222);
    pulse(0);
    rd(4'd4, v); check("R7 rx flag", v, 32'h1);
    rd(4'd7, v); check("R7 tx flag untouched", v, 32'h0);
    wr(4'd1, 32'h33333333);
    wr(4'd2, 32'h44444444);
    pulse(0);
    rd(4'd5, v); check("R8 rx lo kept", v, 32'h11111111);
    rd(4'd6, v); check("R8 rx hi kept", v, 32'h22222222);
    rd(4'd4, v); check("R9 rx flag cleared", v, 32'h0);
    rd(4'd5, v); check("R9 rx lo rejected", v, 32'h0);
    rd(4'd6, v); check("R9 rx hi rejected", v, 32'h0);

    // R7 transmit capture takes the new time
    pulse(1);
    rd(4'd7, v); check("R7 tx flag", v, 32'h1);
    rd(4'd8, v); check("R7 tx lo", v, 32'h33333333);
    rd(4'd9, v); check("R7 tx hi", v, 32'h44444444);
    rd(4'd7, v); check("R9 tx flag cleared", v, 32'h0);

    // R10 register addresses
    rd(4'd0, v); check("R10 rate readback", v, 32'h01000001);
    wr(4'd3, 32'h3);
    rd(4'd3, v); check("R10 ctrl readback", v, 32'h3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule